// File: doc/BRIEF.md
# BCH Error-Location Bit Corrector

This block sits after a BCH decoder and repairs a sector that is held in a byte-addressed RAM inside the block. When `start_i` is accepted, the block captures the decoder's results. These are a count of error positions, a vector of 32-bit words that each carry two 13-bit bit positions, an uncorrectable flag, and two blank-page flags (page read as all zeros or as all ones). The block then visits each reported position in order and inverts the addressed bit in the buffer with a read-modify-write.

Correction is skipped for blank pages and for uncorrectable results. A position whose byte lies beyond the programmed buffer length is not applied, and it raises a sticky range-error flag. The block holds `busy_o` from the cycle after the start is accepted until the cycle in which it pulses `done_o`. It reports a two-bit status. While the block is idle, a host port loads the buffer and reads it back.

Top module: `bch_bitfix`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `range_err_o` are 0 and `status_o` is 2'b00.
- R2: `err_count_i` (0 to 15) sets how many positions are processed. A count of 0 flips nothing and returns status 2'b00.
- R3: Position i comes from word i/2, which occupies `err_words_i[32*w+31:32*w]`. An even i uses word bits [12:0] and an odd i uses bits [28:16]. Bits [15:13] and [31:29] are ignored.
- R4: For each position p, the bit p[2:0] of buffer byte p>>3 is inverted. A position listed twice therefore leaves the byte unchanged.
- R5: If `blank0_i` or `blankf_i` is set at start, no bit is flipped and the status is 2'b10. This takes priority over the uncorrectable flag.
- R6: If `uncor_i` is set at start and neither blank flag is set, no bit is flipped and the status is 2'b01.
- R7: Otherwise the status is 2'b00. The status is set when the start is accepted and holds until the next accepted start.
- R8: Each in-range position costs 2 cycles and each out-of-range position costs 1 cycle. `done_o` is a one-cycle pulse D clock edges after the accepting edge, where D is the sum of these costs (D is 0 when nothing is processed, so done appears right after that edge). `busy_o` is high from the accepting edge through the done cycle.
- R9: A position whose byte is at or above min(`buf_len_i`, 1024) is skipped and sets `range_err_o`. That flag stays set until the next accepted start clears it.
- R10: A start while `busy_o` is high is ignored and does not change the run in progress.
- R11: A host write (`host_we_i`) updates the byte at `host_addr_i` only while `busy_o` is low. `host_rdata_o` shows that byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| err_count_i | input | 4 | Number of positions to apply |
| err_words_i | input | 256 | Eight words, two 13-bit positions each |
| uncor_i | input | 1 | Decoder reports an uncorrectable result |
| blank0_i | input | 1 | Page read as all 0x00 |
| blankf_i | input | 1 | Page read as all 0xFF |
| buf_len_i | input | 11 | Buffer length in bytes |
| host_we_i | input | 1 | Host byte write |
| host_addr_i | input | 10 | Host byte address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Byte at the host address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 corrected, 01 uncorrectable, 10 blank |
| range_err_o | output | 1 | Sticky out-of-range position flag |

## Verification
The bench fills the spare bits of every error word with ones. A design that decoded too wide a field would then flip the wrong byte. It lists one position twice, which would leave a stray flip in a design that set bits instead of inverting them. It uses a length of zero and a length above the buffer size. A wrong bound would apply an out-of-range flip or miss the sticky flag, and a wrong cost per position would move `done_o` by a cycle. It also fires start and a host write in the middle of a run, which would corrupt the buffer or restart the walk in a design that accepted them while busy.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int POS_W  = 13;
  localparam int HI_LSB = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FIX_OK    = 2'b00,
    FIX_UNCOR = 2'b01,
    FIX_BLANK = 2'b10
  } fix_status_e;

  typedef enum logic [1:0] {
    WK_IDLE, WK_PICK, WK_FLIP, WK_END
  } walk_state_e;

  function automatic logic [POS_W-1:0] field_of(logic [WORD_W-1:0] w, logic odd);
    return odd ? w[HI_LSB +: POS_W] : w[POS_W-1:0];
  endfunction

  function automatic logic [POS_W-4:0] byte_of(logic [POS_W-1:0] p);
    return p[POS_W-1:3];
  endfunction

  function automatic logic [2:0] bit_of(logic [POS_W-1:0] p);
    return p[2:0];
  endfunction

  function automatic logic [7:0] flip_bit(logic [7:0] b, logic [2:0] k);
    return b ^ (8'h01 << k);
  endfunction
endpackage

// File: rtl/bfx_byte_ram.sv
module bfx_byte_ram #(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [7:0]        a_wdata,
  output logic [7:0]        a_rdata,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [7:0]        b_wdata,
  output logic [7:0]        b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we)      mem[b_addr] <= b_wdata;
    else if (a_we) mem[a_addr] <= a_wdata;
  end

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];
endmodule

// File: rtl/bfx_walker.sv
module bfx_walker
  import bfx_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 4,
  localparam int NPOS   = 1 << CNT_W,
  localparam int NWORDS = NPOS / 2,
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [NWORDS*WORD_W-1:0] words_i,
  input  logic                     uncor_i,
  input  logic                     blank_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic [7:0]               rdata_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic                     we_o,
  output logic [7:0]               wdata_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [1:0]               status_o,
  output logic                     range_err_o,
  output logic                     skip_o,
  output logic [LEN_W-1:0]         lim_o
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(1 << ADDR_W);

  walk_state_e           st_q;
  logic [POS_W-1:0]      pos_in [NPOS];
  logic [POS_W-1:0]      pos_q  [NPOS];
  logic [NWORDS-1:0]     spare;
  logic                  unused_spare;
  logic [CNT_W-1:0]      cnt_q, idx_q;
  logic [LEN_W-1:0]      lim_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [2:0]            bit_q;
  logic                  skip_q, range_q;
  fix_status_e           status_q;

  genvar g;
  generate
    for (g = 0; g < NPOS; g++) begin : g_unpack
      assign pos_in[g] = field_of(words_i[WORD_W*(g/2) +: WORD_W], (g % 2) == 1);
    end
    for (g = 0; g < NWORDS; g++) begin : g_spare
      assign spare[g] = ^{words_i[WORD_W*g + POS_W +: HI_LSB-POS_W],
                          words_i[WORD_W*g + HI_LSB + POS_W +: WORD_W-HI_LSB-POS_W]};
    end
  endgenerate
  assign unused_spare = ^spare;

  logic [POS_W-1:0]   cur_pos;
  logic [POS_W-4:0]   cur_byte;
  logic               in_range, last, accept;

  assign cur_pos  = pos_q[idx_q];
  assign cur_byte = byte_of(cur_pos);
  assign in_range = int'(cur_byte) < int'(lim_q);
  assign last     = (idx_q == cnt_q - CNT_W'(1));
  assign accept   = start_i && (st_q == WK_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= WK_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      lim_q    <= '0;
      addr_q   <= '0;
      bit_q    <= '0;
      skip_q   <= 1'b0;
      range_q  <= 1'b0;
      status_q <= FIX_OK;
    end else begin
      case (st_q)
        WK_IDLE: if (accept) begin
          cnt_q   <= count_i;
          idx_q   <= '0;
          lim_q   <= (len_i > DEPTH_L) ? DEPTH_L : len_i;
          range_q <= 1'b0;
          skip_q  <= blank_i || uncor_i;
          if (blank_i)      status_q <= FIX_BLANK;
          else if (uncor_i) status_q <= FIX_UNCOR;
          else              status_q <= FIX_OK;
          if (blank_i || uncor_i || count_i == '0) st_q <= WK_END;
          else                                     st_q <= WK_PICK;
        end
        WK_PICK: begin
          if (in_range) begin
            addr_q <= ADDR_W'(cur_byte);
            bit_q  <= bit_of(cur_pos);
            st_q   <= WK_FLIP;
          end else begin
            range_q <= 1'b1;
            if (last) st_q <= WK_END;
            else      idx_q <= idx_q + CNT_W'(1);
          end
        end
        WK_FLIP: begin
          if (last) st_q <= WK_END;
          else begin
            idx_q <= idx_q + CNT_W'(1);
            st_q  <= WK_PICK;
          end
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) pos_q <= pos_in;
  end

  assign addr_o      = addr_q;
  assign we_o        = (st_q == WK_FLIP);
  assign wdata_o     = flip_bit(rdata_i, bit_q);
  assign busy_o      = (st_q != WK_IDLE);
  assign done_o      = (st_q == WK_END);
  assign status_o    = status_q;
  assign range_err_o = range_q;
  assign skip_o      = skip_q;
  assign lim_o       = lim_q;
endmodule

// File: rtl/bch_bitfix.sv
module bch_bitfix #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 4,
  localparam int NWORDS = (1 << CNT_W) / 2,
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     err_count_i,
  input  logic [NWORDS*32-1:0] err_words_i,
  input  logic                 uncor_i,
  input  logic                 blank0_i,
  input  logic                 blankf_i,
  input  logic [LEN_W-1:0]     buf_len_i,
  input  logic                 host_we_i,
  input  logic [ADDR_W-1:0]    host_addr_i,
  input  logic [7:0]           host_wdata_i,
  output logic [7:0]           host_rdata_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [1:0]           status_o,
  output logic                 range_err_o
);
  logic              fix_we;
  logic [ADDR_W-1:0] fix_addr;
  logic [7:0]        fix_wdata, fix_rdata;
  logic              skip_run;
  logic [LEN_W-1:0]  lim_len;
  logic              host_wr_ok;

  assign host_wr_ok = host_we_i && !busy_o;

  bfx_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .count_i(err_count_i), .words_i(err_words_i),
    .uncor_i(uncor_i), .blank_i(blank0_i || blankf_i), .len_i(buf_len_i),
    .rdata_i(fix_rdata), .addr_o(fix_addr), .we_o(fix_we), .wdata_o(fix_wdata),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .range_err_o(range_err_o), .skip_o(skip_run), .lim_o(lim_len)
  );

  bfx_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk),
    .a_we(host_wr_ok), .a_addr(host_addr_i), .a_wdata(host_wdata_i), .a_rdata(host_rdata_o),
    .b_we(fix_we), .b_addr(fix_addr), .b_wdata(fix_wdata), .b_rdata(fix_rdata)
  );
endmodule

// File: rtl/bfx_checker.sv
module bfx_checker #(
  parameter int ADDR_W = 10,
  localparam int LEN_W = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic              range_err_o,
  input logic              fix_we,
  input logic [ADDR_W-1:0] fix_addr,
  input logic              skip_run,
  input logic [LEN_W-1:0]  lim_len
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R10
  AST_NO_WRITE_ON_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && skip_run) |-> !fix_we); // R5
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> ({1'b0, fix_addr} < lim_len)); // R9
  AST_RANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (range_err_o && !(start_i && !busy_o)) |=> range_err_o); // R9
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(status_o)); // R7
  AST_IDLE_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !fix_we); // R11
endmodule

bind bch_bitfix bfx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .status_o(status_o), .range_err_o(range_err_o), .fix_we(fix_we),
  .fix_addr(fix_addr), .skip_run(skip_run), .lim_len(lim_len)
);

// File: tb/bch_bitfix_bench.sv
module bch_bitfix_bench;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 1024;

  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0]   cnt = '0;
  logic [255:0] words = '0;
  logic         uncor = 1'b0, blank0 = 1'b0, blankf = 1'b0;
  logic [10:0]  blen = '0;
  logic         hwe = 1'b0;
  logic [9:0]   haddr = '0;
  logic [7:0]   hwdata = '0, hrdata;
  logic         busy, done, rng;
  logic [1:0]   status;

  int vectors = 0, fails = 0;
  logic checking = 1'b0;

  logic [7:0] exp_mem [DEPTH];
  logic       m_busy = 1'b0, m_done = 1'b0, m_rng = 1'b0;
  logic [1:0] m_status = 2'b00;
  int         m_left = 0;

  bch_bitfix u_bch_bitfix (
    .clk(clk), .rst_n(rst_n), .start_i(start), .err_count_i(cnt), .err_words_i(words),
    .uncor_i(uncor), .blank0_i(blank0), .blankf_i(blankf), .buf_len_i(blen),
    .host_we_i(hwe), .host_addr_i(haddr), .host_wdata_i(hwdata), .host_rdata_o(hrdata),
    .busy_o(busy), .done_o(done), .status_o(status), .range_err_o(rng)
  );

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      automatic logic was_busy = m_busy;
      if (hwe && !was_busy) exp_mem[haddr] = hwdata;
      if (was_busy) begin
        if (m_done) begin m_busy = 1'b0; m_done = 1'b0; end
        else begin m_left--; m_done = (m_left == 0); end
      end else if (start) begin
        automatic int lim = (blen > 11'd1024) ? 1024 : int'(blen);
        automatic int cost = 0;
        m_rng = 1'b0;
        if (blank0 || blankf) m_status = 2'b10;
        else if (uncor)       m_status = 2'b01;
        else begin
          m_status = 2'b00;
          for (int i = 0; i < int'(cnt); i++) begin
            automatic int p = int'(words[32*(i/2) + 16*(i%2) +: 13]);
            if ((p / 8) < lim) begin
              exp_mem[p/8] = exp_mem[p/8] ^ (8'd1 << (p % 8));
              cost += 2;
            end else begin
              m_rng = 1'b1;
              cost += 1;
            end
          end
        end
        m_busy = 1'b1; m_left = cost; m_done = (cost == 0);
      end
    end
  end

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(busy == m_busy, "R8 R10 busy", busy, m_busy);
      chk(done == m_done, "R8 done", done, m_done);
      if (!m_busy || m_done) begin
        chk(status == m_status, "R5 R6 R7 status", status, m_status);
        chk(rng == m_rng, "R9 range_err", rng, m_rng);
      end
    end
  end

  task automatic host_wr(input int a, input int d);
    @(negedge clk); hwe = 1'b1; haddr = 10'(a); hwdata = 8'(d);
    @(negedge clk); hwe = 1'b0;
  endtask

  task automatic set_pos(input int i, input int p);
    words[32*(i/2) + 16*(i%2) +: 13] = 13'(p);
  endtask

  task automatic bg_words();
    for (int w = 0; w < 8; w++) words[32*w +: 32] = 32'hE000_E000;
  endtask

  task automatic run(input int n, input int len, input logic b0, input logic bf, input logic uc);
    @(negedge clk);
    cnt = 4'(n); blen = 11'(len); blank0 = b0; blankf = bf; uncor = uc; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 100 && m_busy; k++) @(negedge clk);
  endtask

  task automatic mem_check(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); haddr = 10'(a); #1;
      chk(hrdata == exp_mem[a], tag, hrdata, exp_mem[a]);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(busy == 0 && done == 0 && rng == 0 && status == 2'b00, "R1 reset outputs",
        {busy, done, rng, status}, 0);
    checking = 1'b1;
    // R11: preload the buffer while idle
    for (int a = 0; a < DEPTH; a++) host_wr(a, (a * 37 + 5) % 256);
    mem_check("R11 preload");

    // R3 R4: three in-range flips, spare bits set in every word
    bg_words(); set_pos(0, 10); set_pos(1, 4095); set_pos(2, 0);
    run(3, 512, 0, 0, 0);
    mem_check("R3 R4 basic flips");

    // R2 R4 R9: full count, duplicate position, some beyond the length
    bg_words();
    for (int i = 0; i < 15; i++) set_pos(i, (i * 611 + 7) % 8192);
    set_pos(5, (4 * 611 + 7) % 8192);
    run(15, 200, 0, 0, 0);
    mem_check("R2 R4 R9 full count");

    // R5: blank flags suppress flips
    run(5, 1024, 1, 0, 0);
    mem_check("R5 blank zero");
    run(5, 1024, 0, 1, 1);
    mem_check("R5 blank ones");
    // R6: uncorrectable suppresses flips
    run(5, 1024, 0, 0, 1);
    mem_check("R6 uncorrectable");
    // R2 R7: zero count
    run(0, 1024, 0, 0, 0);
    // R9: length above buffer is clamped, length zero rejects everything
    bg_words(); set_pos(0, 8191); set_pos(1, 8184);
    run(2, 2000, 0, 0, 0);
    run(1, 0, 0, 0, 0);
    mem_check("R9 clamp and zero length");

    // R10 R11: start and host write in the middle of a run are ignored
    bg_words(); set_pos(0, 100); set_pos(1, 200); set_pos(2, 300); set_pos(3, 400);
    @(negedge clk);
    cnt = 4'd4; blen = 11'd1024; blank0 = 0; blankf = 0; uncor = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    set_pos(0, 16); cnt = 4'd1; blank0 = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0; blank0 = 1'b0;
    host_wr(3, 8'hAA);
    for (int k = 0; k < 100 && m_busy; k++) @(negedge clk);
    mem_check("R10 R11 busy ignores start and write");

    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule